// File: doc/BRIEF.md
# Serial Maximum Finder with Index

This block scans a fixed-length stream of unsigned samples, taking one sample on each clock cycle where the strobe is high. It tracks the largest value seen since the scan began and the position of that value in the stream. When the last sample of the stream is taken, it raises a one-cycle completion flag. It then keeps its results until the next scan is launched.

The datapath is a single magnitude comparator. Its result steers a multiplexer that either reloads the maximum register or keeps it. One counter gives the position of each accepted sample. This serial form uses one sample slot per cycle and needs no comparator tree. The block fits a design where samples come out of a memory or a channel one at a time and area matters more than latency. Because the comparison is strict, the earliest position wins when two samples tie for the maximum.

A start pulse clears the results and opens a scan. A start pulse that arrives during a scan abandons that scan and opens a new one from position zero.

Top module: `serial_max_finder`

## Requirements
- R1: A synchronous active-high reset leaves the block idle with `max_val`, `max_idx` and `done` all zero on the cycle after the reset edge.
- R2: A cycle with `start` high clears `max_val` and `max_idx` to zero and `done` to low. The cleared values appear after that clock edge.
- R3: During a scan, an accepted sample that is strictly greater (unsigned) than `max_val` replaces `max_val`. Its position, counted from 0 as the number of samples accepted earlier in the scan, goes into `max_idx`. Both are visible after the accepting edge.
- R4: During a scan, an accepted sample that is equal to or smaller than `max_val` leaves `max_val` and `max_idx` unchanged, so the earliest position is kept when samples tie.
- R5: Cycles with `in_valid` low take no sample and do not advance the position. The value on `in_data` during those cycles has no effect.
- R6: A scan takes exactly 1024 samples. `done` is high for exactly one cycle, on the cycle after the edge that takes sample 1023, and is low at every other time.
- R7: After a scan ends, valid samples are ignored, and `max_val` and `max_idx` hold until the next `start` or reset.
- R8: `start` during a scan aborts it. Counting restarts at position 0, and a sample offered in the same cycle as `start` is not taken.
- R9: Samples are compared as unsigned 8-bit numbers, so 0x80 is greater than 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that opens a new scan (aborts a running one) |
| in_valid | input | 1 | Strobe marking `in_data` as a sample |
| in_data | input | 8 | Unsigned sample |
| max_val | output | 8 | Largest sample seen in the current or last scan |
| max_idx | output | 10 | Position of the earliest sample equal to `max_val` |
| done | output | 1 | One-cycle pulse after the final sample of a scan |

## Verification
A corrupted position counter moves the completion pulse by one or more samples. It also puts a wrong value in `max_idx` at the next sample that replaces the maximum, so the error shows within one scan. A wrong choice in the compare step shows up the cycle after the offending sample: on ties, `max_idx` moves to a later position, and on top-bit values the comparison turns signed. A scan state that stays active after completion lets post-scan samples disturb the held results on the next cycle. The stimulus is built to expose each of these faults.

// File: rtl/serial_max_finder.sv
module serial_max_finder #(
  parameter int DATA_W      = 8,
  parameter int NUM_SAMPLES = 1024,
  localparam int IDX_W      = $clog2(NUM_SAMPLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] max_val,
  output logic [IDX_W-1:0]  max_idx,
  output logic              done
);

  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(NUM_SAMPLES - 1);

  logic             busy;
  logic [IDX_W-1:0] pos;

  wire accept     = busy & in_valid & ~start;
  wire is_greater = in_data > max_val;
  wire at_last    = pos == LAST_POS;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      pos     <= '0;
      max_val <= '0;
      max_idx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        pos     <= '0;
        max_val <= '0;
        max_idx <= '0;
      end else if (accept) begin
        pos <= pos + 1'b1;
        if (is_greater) begin
          max_val <= in_data;
          max_idx <= pos;
        end
        if (at_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (max_val == '0 && max_idx == '0 && !done && !busy)); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst) start |=> (max_val == '0 && max_idx == '0 && !done && busy && pos == '0)); // R2
  AST_GREATER_LOADS: assert property (@(posedge clk) disable iff (rst) (accept && is_greater) |=> (max_val == $past(in_data) && max_idx == $past(pos))); // R3
  AST_NOT_GREATER_KEEPS: assert property (@(posedge clk) disable iff (rst) (accept && !is_greater) |=> ($stable(max_val) && $stable(max_idx))); // R4
  AST_IDLE_STROBE_KEEPS: assert property (@(posedge clk) disable iff (rst) (busy && !in_valid && !start) |=> ($stable(pos) && $stable(max_val) && $stable(max_idx))); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
  AST_DONE_ENDS_SCAN: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && pos == '0)); // R6
  AST_POST_SCAN_HOLD: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> ($stable(max_val) && $stable(max_idx) && !done)); // R7
  AST_MAX_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst) (busy && !start) |=> (max_val >= $past(max_val))); // R9

endmodule

// File: tb/serial_max_finder_bench.sv
module serial_max_finder_bench;

  typedef struct packed {
    logic [3:0]  kind;
    logic [11:0] a;
    logic [7:0]  b;
    logic [7:0]  exp_max;
    logic [11:0] exp_idx;
    logic [3:0]  gap;
  } scan_t;

  localparam int NSCAN = 7;
  localparam scan_t SCANS [NSCAN] = '{
    '{4'd0, 12'd0,    8'h55, 8'h55, 12'd0,    4'd0},
    '{4'd1, 12'd0,    8'h00, 8'hFF, 12'd255,  4'd3},
    '{4'd2, 12'd700,  8'h10, 8'hFF, 12'd700,  4'd0},
    '{4'd3, 12'd300,  8'h03, 8'hC8, 12'd300,  4'd5},
    '{4'd4, 12'd0,    8'h00, 8'hFF, 12'd0,    4'd0},
    '{4'd5, 12'd1023, 8'h00, 8'h80, 12'd1023, 4'd2},
    '{4'd0, 12'd0,    8'h00, 8'h00, 12'd0,    4'd7}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [7:0] max_val;
  logic [9:0] max_idx;
  logic       done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_max_finder u_serial_max_finder (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_data(in_data), .max_val(max_val), .max_idx(max_idx), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic v, input logic [7:0] d);
    start = s; in_valid = v; in_data = d;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; in_data = 8'h00;
  endtask

  function automatic logic [7:0] gen(input scan_t sc, input int i);
    case (sc.kind)
      4'd1:    return 8'(i);
      4'd2:    return (i == int'(sc.a)) ? 8'hFF : sc.b;
      4'd3:    return (i == int'(sc.a) || i == 1000) ? 8'hC8 : sc.b;
      4'd4:    return 8'(255 - (i % 256));
      4'd5:    return (i == int'(sc.a)) ? 8'h80 : 8'h7F;
      default: return sc.b;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset max_val", int'(max_val), 0);
    check("R1 reset max_idx", int'(max_idx), 0);
    check("R1 reset done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int s = 0; s < NSCAN; s++) begin
      int early_done = 0;
      cyc(1'b1, 1'b0, 8'h00);
      check("R2 start clears max_val", int'(max_val), 0);
      for (int i = 0; i < 1024; i++) begin
        if (SCANS[s].gap != 0 && (i % int'(SCANS[s].gap)) == int'(SCANS[s].gap) - 1) begin
          cyc(1'b0, 1'b0, 8'hEE);
          if (done) early_done++;
        end
        cyc(1'b0, 1'b1, gen(SCANS[s], i));
        if (i < 1023 && done) early_done++;
      end
      check("R6 done after sample 1023", int'(done), 1);
      check("R6 no early done", early_done, 0);
      check("R3 scan max_val", int'(max_val), int'(SCANS[s].exp_max));
      check("R3 scan max_idx", int'(max_idx), int'(SCANS[s].exp_idx));
      cyc(1'b0, 1'b1, 8'hFF);
      check("R6 done one cycle", int'(done), 0);
      check("R7 hold max_val", int'(max_val), int'(SCANS[s].exp_max));
      check("R7 hold max_idx", int'(max_idx), int'(SCANS[s].exp_idx));
    end

    // R7: many ignored samples after a scan
    for (int k = 0; k < 20; k++) cyc(1'b0, 1'b1, 8'(200 + k));
    check("R7 post-scan max_val", int'(max_val), 0);
    check("R7 post-scan done", int'(done), 0);

    // Directed in-scan sequence: R3, R4, R5
    cyc(1'b1, 1'b0, 8'h00);
    cyc(1'b0, 1'b1, 8'h05);
    check("R3 first sample max_val", int'(max_val), 5);
    check("R3 first sample max_idx", int'(max_idx), 0);
    cyc(1'b0, 1'b1, 8'h09);
    check("R3 greater max_idx", int'(max_idx), 1);
    cyc(1'b0, 1'b1, 8'h09);
    check("R4 tie keeps max_idx", int'(max_idx), 1);
    cyc(1'b0, 1'b1, 8'h03);
    check("R4 smaller keeps max_val", int'(max_val), 9);
    cyc(1'b0, 1'b0, 8'hC0);
    check("R5 invalid ignored max_val", int'(max_val), 9);
    cyc(1'b0, 1'b1, 8'h0A);
    check("R5 index not advanced", int'(max_idx), 4);
    cyc(1'b0, 1'b1, 8'h7F);
    cyc(1'b0, 1'b1, 8'h80);
    check("R9 unsigned compare max_val", int'(max_val), 128);
    check("R9 unsigned compare max_idx", int'(max_idx), 6);

    // R8: abort with a sample offered alongside start
    cyc(1'b1, 1'b1, 8'hFF);
    check("R8 abort clears max_val", int'(max_val), 0);
    check("R8 abort clears max_idx", int'(max_idx), 0);
    begin
      int early = 0;
      for (int i = 0; i < 1024; i++) begin
        cyc(1'b0, 1'b1, (i == 1023) ? 8'h22 : 8'h00);
        if (i < 1023 && done) early++;
      end
      check("R8 restart counts from zero", early, 0);
      check("R8 done after full restart", int'(done), 1);
      check("R8 last position", int'(max_idx), 1023);
    end

    // R1: reset after a completed scan
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset max_val", int'(max_val), 0);
    check("R1 mid-run reset max_idx", int'(max_idx), 0);
    check("R1 mid-run reset done", int'(done), 0);
    cyc(1'b0, 1'b1, 8'h44);
    check("R1 idle after reset", int'(max_val), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule